// File: doc/BRIEF.md
# Runahead Store-to-Load Forwarding Cache

This block is a small scratch cache used only while the core runs ahead of a long-latency miss. Stores that pseudo-retire during that speculative period write their bytes into it, together with a poison flag. The flag says whether the stored value depends on an outstanding miss. Later loads in the same period probe it, so a value can pass from a store to a load without touching architectural memory.

Results only have to be right most of the time. There is no writeback and no coherence, and a line may be overwritten by a conflicting store at any moment. When a load misses here, it goes to the normal data cache. A single flush pulse, raised when the speculative period ends, invalidates every line.

The default organisation holds 512 data bytes as 64 direct-mapped lines of 8 bytes. Each line keeps a tag, a valid bit, one written bit per byte and one poison bit. Stores carry a whole line-aligned data word with byte enables. Loads carry a byte mask and get a registered response one cycle later.

Top module: `sfc_runahead_cache`

## Requirements
- R1: After reset, every load responds with a miss.
- R2: A load presented in cycle t responds in cycle t+1 with `ld_rsp_valid` high. If an earlier store wrote every requested byte of the same line and tag, the response is a hit.
- R3: A load that requests any byte not yet written in the matching line misses. Every miss returns `ld_data` of zero and `ld_inv` of zero.
- R4: On a hit, byte b of `ld_data` (bits 8b+7..8b) carries the last value stored to that byte when `ld_be[b]` is 1, and is zero when `ld_be[b]` is 0.
- R5: Address bits [2:0] are ignored. Bits [8:3] select the line and bits [31:9] form the tag. A load whose tag differs from the line's tag misses.
- R6: A store whose tag differs from a valid line's tag replaces that line. Its earlier written bits and poison are discarded, so only the new store's bytes hit, and they carry the new store's poison.
- R7: A store with the same tag merges its enabled bytes into the line. The line's poison becomes the OR of its old poison and the store's `st_inv`.
- R8: A flush invalidates all lines from the next cycle on. A store presented in the flush cycle is dropped.
- R9: When a store and a load reach the same line in the same cycle, the load's response reflects the contents from before that store.
- R10: A store with all byte enables zero changes nothing.
- R11: On a hit, `ld_inv` equals the line's poison bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines (end of speculative period) |
| st_valid | input | 1 | Pseudo-retired store present |
| st_addr | input | 32 | Store address |
| st_data | input | 64 | Line-aligned store data |
| st_be | input | 8 | Store byte enables |
| st_inv | input | 1 | Store value is miss-dependent |
| ld_valid | input | 1 | Load probe present |
| ld_addr | input | 32 | Load address |
| ld_be | input | 8 | Requested bytes |
| ld_rsp_valid | output | 1 | Response for the load of the previous cycle |
| ld_hit | output | 1 | All requested bytes were found |
| ld_data | output | 64 | Masked line data on hit, zero otherwise |
| ld_inv | output | 1 | Poison of the hit line |

## Verification
Some rules hold on every cycle, and the assertions check those continuously:
- a flush leaves no valid line;
- a store leaves its enabled bytes marked written;
- a replacing store leaves exactly its own bytes written;
- a merging store never clears poison;
- a miss response is always quiet, with zero data and zero poison;
- a load right after a flush misses.

Other behaviour only shows up through the bench's scenarios, which compare responses against an independent per-line model:
- the exact returned byte values;
- the full sweep of 256 request masks over partly written lines;
- the ordering of a store and a load to the same line in the same cycle;
- that stores with empty enables and stores in the flush cycle have no effect.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  // Outcome of one probe of the line array, exposed for assertions.
  typedef enum logic [1:0] {
    PROBE_EMPTY   = 2'd0,
    PROBE_TAGDIFF = 2'd1,
    PROBE_PARTIAL = 2'd2,
    PROBE_HIT     = 2'd3
  } probe_kind_e;
endpackage

// File: rtl/sfc_addr_split.sv
module sfc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  logic unused_offset;

  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^addr[OFF_W-1:0];
endmodule

// File: rtl/sfc_line_array.sv
module sfc_line_array #(
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 8,
  parameter int IDX_W      = 6,
  parameter int TAG_W      = 23,
  localparam int DATA_W    = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [LINE_BYTES-1:0] wr_be,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  wr_inv,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic                  rd_valid,
  output logic [TAG_W-1:0]      rd_tag,
  output logic [LINE_BYTES-1:0] rd_written,
  output logic                  rd_inv,
  output logic [DATA_W-1:0]     rd_data
);
  logic [LINES-1:0]      valid_q;
  logic [TAG_W-1:0]      tag_q     [LINES];
  logic [LINE_BYTES-1:0] written_q [LINES];
  logic                  inv_q     [LINES];
  logic [DATA_W-1:0]     data_q    [LINES];

  // Named internal events
  logic                  wr_commit;
  logic                  wr_replace;
  logic [LINE_BYTES-1:0] next_written;
  logic                  next_inv;

  function automatic logic [DATA_W-1:0] merge_bytes(
    input logic [DATA_W-1:0] old_d,
    input logic [DATA_W-1:0] new_d,
    input logic [LINE_BYTES-1:0] be
  );
    logic [DATA_W-1:0] r;
    r = old_d;
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (be[b]) r[b*8 +: 8] = new_d[b*8 +: 8];
    end
    return r;
  endfunction

  assign wr_commit    = wr_en && !flush;
  assign wr_replace   = !valid_q[wr_idx] || (tag_q[wr_idx] != wr_tag);
  assign next_written = (wr_replace ? '0 : written_q[wr_idx]) | wr_be;
  assign next_inv     = (wr_replace ? 1'b0 : inv_q[wr_idx]) | wr_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]     <= '0;
        written_q[i] <= '0;
        inv_q[i]     <= 1'b0;
      end
    end else if (flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx]   <= 1'b1;
      tag_q[wr_idx]     <= wr_tag;
      written_q[wr_idx] <= next_written;
      inv_q[wr_idx]     <= next_inv;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_commit) data_q[wr_idx] <= merge_bytes(data_q[wr_idx], wr_data, wr_be);
  end

  assign rd_valid   = valid_q[rd_idx];
  assign rd_tag     = tag_q[rd_idx];
  assign rd_written = written_q[rd_idx];
  assign rd_inv     = inv_q[rd_idx];
  assign rd_data    = data_q[rd_idx];

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  assert_store_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> ((written_q[$past(wr_idx)] & $past(wr_be)) == $past(wr_be)));

  assert_replace_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && wr_replace) |=> (written_q[$past(wr_idx)] == $past(wr_be)));

  assert_inv_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !wr_replace && inv_q[wr_idx]) |=> inv_q[$past(wr_idx)]);
endmodule

// File: rtl/sfc_probe.sv
module sfc_probe
  import sfc_pkg::*;
#(
  parameter int LINE_BYTES = 8,
  parameter int TAG_W      = 23,
  localparam int DATA_W    = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_valid,
  input  logic [TAG_W-1:0]      ld_tag,
  input  logic [LINE_BYTES-1:0] ld_be,
  input  logic                  rd_valid,
  input  logic [TAG_W-1:0]      rd_tag,
  input  logic [LINE_BYTES-1:0] rd_written,
  input  logic                  rd_inv,
  input  logic [DATA_W-1:0]     rd_data,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  rsp_inv,
  output probe_kind_e           kind
);
  logic [DATA_W-1:0] req_bits;

  function automatic logic covers(
    input logic [LINE_BYTES-1:0] have,
    input logic [LINE_BYTES-1:0] want
  );
    return (have & want) == want;
  endfunction

  genvar b;
  generate
    for (b = 0; b < LINE_BYTES; b++) begin : g_mask
      assign req_bits[b*8 +: 8] = {8{ld_be[b]}};
    end
  endgenerate

  always_comb begin
    if (!rd_valid)                    kind = PROBE_EMPTY;
    else if (rd_tag != ld_tag)        kind = PROBE_TAGDIFF;
    else if (!covers(rd_written, ld_be)) kind = PROBE_PARTIAL;
    else                              kind = PROBE_HIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      rsp_inv   <= 1'b0;
    end else begin
      rsp_valid <= ld_valid;
      if (ld_valid && kind == PROBE_HIT) begin
        rsp_hit  <= 1'b1;
        rsp_data <= rd_data & req_bits;
        rsp_inv  <= rd_inv;
      end else begin
        rsp_hit  <= 1'b0;
        rsp_data <= '0;
        rsp_inv  <= 1'b0;
      end
    end
  end

  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0 && !rsp_inv));

  assert_hit_has_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
endmodule

// File: rtl/sfc_runahead_cache.sv
module sfc_runahead_cache #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int DATA_W    = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  st_valid,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [DATA_W-1:0]     st_data,
  input  logic [LINE_BYTES-1:0] st_be,
  input  logic                  st_inv,
  input  logic                  ld_valid,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [LINE_BYTES-1:0] ld_be,
  output logic                  ld_rsp_valid,
  output logic                  ld_hit,
  output logic [DATA_W-1:0]     ld_data,
  output logic                  ld_inv
);
  import sfc_pkg::*;

  logic [IDX_W-1:0]      st_idx, ld_idx;
  logic [TAG_W-1:0]      st_tag, ld_tag;
  logic                  store_en;
  logic                  rd_valid, rd_inv;
  logic [TAG_W-1:0]      rd_tag;
  logic [LINE_BYTES-1:0] rd_written;
  logic [DATA_W-1:0]     rd_data;
  probe_kind_e           probe_kind;

  assign store_en = st_valid && (|st_be);

  sfc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_st_split (
    .addr(st_addr), .idx(st_idx), .tag(st_tag));

  sfc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ld_split (
    .addr(ld_addr), .idx(ld_idx), .tag(ld_tag));

  sfc_line_array #(.LINES(LINES), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(store_en), .wr_idx(st_idx), .wr_tag(st_tag), .wr_be(st_be),
    .wr_data(st_data), .wr_inv(st_inv),
    .rd_idx(ld_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_written(rd_written), .rd_inv(rd_inv), .rd_data(rd_data));

  sfc_probe #(.LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)) u_probe (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_be(ld_be),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_written(rd_written),
    .rd_inv(rd_inv), .rd_data(rd_data),
    .rsp_valid(ld_rsp_valid), .rsp_hit(ld_hit), .rsp_data(ld_data),
    .rsp_inv(ld_inv), .kind(probe_kind));

  assert_flush_kills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 ld_valid |=> !ld_hit);

  assert_empty_probe_misses_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && probe_kind == PROBE_EMPTY) |=> !ld_hit);
endmodule

// File: tb/sfc_runahead_cache_test.sv
`timescale 1ns/1ps
module sfc_runahead_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic        st_inv = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [7:0]  ld_be = '0;
  logic        ld_rsp_valid, ld_hit, ld_inv;
  logic [63:0] ld_data;

  int checks = 0;
  int fails  = 0;

  // Reference model built from the requirements
  logic        m_v [64];
  logic [22:0] m_t [64];
  logic [7:0]  m_w [64];
  logic        m_i [64];
  logic [63:0] m_d [64];

  always #2 clk = ~clk;

  sfc_runahead_cache uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_inv(st_inv),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_rsp_valid(ld_rsp_valid), .ld_hit(ld_hit), .ld_data(ld_data), .ld_inv(ld_inv));

  function automatic logic [31:0] mk_addr(input logic [22:0] t, input int idx, input int off);
    return {t, 6'(idx), 3'(off)};
  endfunction

  function automatic logic [63:0] pattern(input int idx, input int salt);
    logic [63:0] d;
    for (int b = 0; b < 8; b++) d[b*8 +: 8] = 8'(idx * 7 + b * 13 + salt * 29 + 1);
    return d;
  endfunction

  task automatic step(input logic sv, input logic [31:0] sa, input logic [63:0] sd,
                      input logic [7:0] sb, input logic si,
                      input logic lv, input logic [31:0] la, input logic [7:0] lb,
                      input logic fl, input string req);
    int li, si_x;
    logic e_hit, e_inv, repl;
    logic [63:0] e_data;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb; st_inv = si;
    ld_valid = lv; ld_addr = la; ld_be = lb; flush = fl;
    li = int'(la[8:3]);
    e_hit = m_v[li] && (m_t[li] == la[31:9]) && ((m_w[li] & lb) == lb);
    e_inv = e_hit && m_i[li];
    e_data = '0;
    if (e_hit)
      for (int b = 0; b < 8; b++) if (lb[b]) e_data[b*8 +: 8] = m_d[li][b*8 +: 8];
    @(posedge clk); #1;
    if (lv) begin
      checks++;
      if (ld_rsp_valid !== 1'b1 || ld_hit !== e_hit || ld_data !== e_data || ld_inv !== e_inv) begin
        fails++;
        $display("FAIL %s: addr=%h be=%h got v=%b hit=%b data=%h inv=%b exp v=1 hit=%b data=%h inv=%b",
                 req, la, lb, ld_rsp_valid, ld_hit, ld_data, ld_inv, e_hit, e_data, e_inv);
      end
    end
    if (fl) begin
      for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
    end else if (sv && sb != 8'h00) begin
      si_x = int'(sa[8:3]);
      repl = !m_v[si_x] || (m_t[si_x] != sa[31:9]);
      if (repl) begin m_w[si_x] = 8'h00; m_i[si_x] = 1'b0; end
      m_v[si_x] = 1'b1; m_t[si_x] = sa[31:9];
      m_w[si_x] = m_w[si_x] | sb;
      m_i[si_x] = m_i[si_x] | si;
      for (int b = 0; b < 8; b++) if (sb[b]) m_d[si_x][b*8 +: 8] = sd[b*8 +: 8];
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be, input logic inv);
    step(1'b1, a, d, be, inv, 1'b0, '0, '0, 1'b0, "none");
  endtask

  task automatic load(input logic [31:0] a, input logic [7:0] be, input string req);
    step(1'b0, '0, '0, '0, 1'b0, 1'b1, a, be, 1'b0, req);
  endtask

  task automatic idle();
    @(negedge clk);
    st_valid = 0; ld_valid = 0; flush = 0; st_be = '0; ld_be = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, got hung exp done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_v[i] = 0; m_t[i] = '0; m_w[i] = '0; m_i[i] = 0; m_d[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty after reset
    for (int i = 0; i < 64; i += 9) load(mk_addr(23'h0, i, 0), 8'hFF, "R1");

    // R2 / R11: fill every line, alternate poison, read back
    for (int i = 0; i < 64; i++) store(mk_addr(23'h12, i, 0), pattern(i, 0), 8'hFF, 1'(i % 2));
    for (int i = 0; i < 64; i++) load(mk_addr(23'h12, i, 0), 8'hFF, "R2_R11");

    // R4: every request mask on a full line
    for (int m = 0; m < 256; m++) load(mk_addr(23'h12, 5, 0), 8'(m), "R4");

    // R5: offset ignored, other tag misses
    for (int o = 0; o < 8; o++) load(mk_addr(23'h12, 9, o), 8'h3C, "R5");
    store(mk_addr(23'h12, 10, 6), pattern(10, 3), 8'h81, 1'b0);
    load(mk_addr(23'h12, 10, 0), 8'hFF, "R5");
    load(mk_addr(23'h13, 11, 0), 8'h01, "R5");
    load(mk_addr(23'h52, 12, 0), 8'hFF, "R5");

    // R3: partial line, all request masks
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0, 1'b1, "R8");
    store(mk_addr(23'h7, 7, 0), pattern(7, 1), 8'h0F, 1'b1);
    for (int m = 0; m < 256; m++) load(mk_addr(23'h7, 7, 0), 8'(m), "R3");

    // R6: conflicting tag replaces line
    store(mk_addr(23'h8, 7, 0), pattern(7, 2), 8'hF0, 1'b0);
    load(mk_addr(23'h7, 7, 0), 8'h01, "R6");
    load(mk_addr(23'h8, 7, 0), 8'hF0, "R6");
    load(mk_addr(23'h8, 7, 0), 8'h0F, "R6");
    load(mk_addr(23'h8, 7, 0), 8'h10, "R6");

    // R7: merge and sticky poison
    store(mk_addr(23'h8, 7, 0), pattern(7, 4), 8'h0F, 1'b1);
    load(mk_addr(23'h8, 7, 0), 8'hFF, "R7");
    store(mk_addr(23'h8, 7, 0), pattern(7, 5), 8'h18, 1'b0);
    load(mk_addr(23'h8, 7, 0), 8'hFF, "R7");
    for (int m = 0; m < 256; m += 17) load(mk_addr(23'h8, 7, 0), 8'(m), "R7");

    // R9: same-cycle store and load to one line
    store(mk_addr(23'h20, 20, 0), pattern(20, 6), 8'h0F, 1'b0);
    step(1'b1, mk_addr(23'h20, 20, 0), pattern(20, 7), 8'hFF, 1'b1,
         1'b1, mk_addr(23'h20, 20, 0), 8'hFF, 1'b0, "R9");
    load(mk_addr(23'h20, 20, 0), 8'hFF, "R9");
    step(1'b1, mk_addr(23'h21, 21, 0), pattern(21, 1), 8'hFF, 1'b0,
         1'b1, mk_addr(23'h21, 21, 0), 8'h01, 1'b0, "R9");
    load(mk_addr(23'h21, 21, 0), 8'h01, "R9");

    // R10: empty byte enables
    store(mk_addr(23'h30, 30, 0), pattern(30, 1), 8'h00, 1'b1);
    load(mk_addr(23'h30, 30, 0), 8'h00, "R10");
    store(mk_addr(23'h40, 20, 0), pattern(20, 9), 8'h00, 1'b1);
    load(mk_addr(23'h20, 20, 0), 8'hFF, "R10");

    // R8: flush with a store in the same cycle
    step(1'b1, mk_addr(23'h44, 44, 0), pattern(44, 1), 8'hFF, 1'b0,
         1'b0, '0, '0, 1'b1, "R8");
    load(mk_addr(23'h44, 44, 0), 8'hFF, "R8");
    for (int i = 0; i < 64; i++) load(mk_addr(23'h12, i, 0), 8'h01, "R8");

    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule